// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes one asynchronous serial line and turns it into characters. A prescaler divides the system clock by 1, 4, 16 or 64, as a two-bit code selects. The divided clock drives an 8-bit reloading rate counter. Each time that counter expires it produces one oversample tick, and each bit lasts sixteen ticks. A frame is one start bit, then 7 or 8 data bits sent LSB first, then either an optional parity bit or a multiprocessor bit, then the stop bits. Static mode inputs select the frame format. Software is expected to change them only while the line is idle.

The receiver state machine has seven states:

- `ST_IDLE`: waits for a falling edge on the synchronised line.
- `ST_START`: confirms the start bit at mid-bit.
- `ST_DATA`: samples each data bit.
- `ST_PAR`: samples the parity bit.
- `ST_MPB`: samples the multiprocessor bit.
- `ST_STOP`: checks the first stop bit and delivers the character.
- `ST_STOP2`: inspects the slot after the first stop bit when two stop bits are selected.

The transitions are:

- IDLE→START on a low sample that follows a high sample.
- START→IDLE when the line is high again at mid-bit (noise).
- START→DATA when the line is still low at mid-bit.
- DATA→MPB, DATA→PAR or DATA→STOP after the last data bit, depending on the format.
- PAR→STOP and MPB→STOP after one bit period.
- STOP→IDLE with one stop bit selected.
- STOP→STOP2 with two stop bits selected.
- STOP2→IDLE when the second stop slot is high.
- STOP2→DATA when that slot is low. The slot is then taken as an already confirmed start bit.

Top module: `serial_frame_rx`

## Requirements
- R1: The clock select code scales the oversample tick: code 0 divides by 1, code 1 by 4, code 2 by 16 and code 3 by 64. One tick occurs every (rate+1)×divisor system clocks, and one bit period is 16 ticks.
- R2: A start is detected only when a low sample follows a high sample. The line is sampled again 8 ticks later. If it is high then, the event is discarded as noise, no character is produced and the receiver returns to idle.
- R3: Data bits are sampled every 16 ticks after the start confirmation, LSB first. With `char7`=1, 7 bits are received and `rx_data[7]` reads 0.
- R4: When parity is enabled and multiprocessor format is off, one parity bit follows the data. `par_err` is set when the count of ones in the data plus the parity bit is odd and `par_odd`=0, or is even and `par_odd`=1.
- R5: In multiprocessor format, one bit follows the data and is output on `mp_bit`. `par_en` and `par_odd` are then ignored and `par_err` stays 0. Outside this format `mp_bit` is 0.
- R6: Only the first stop bit is checked. If it samples 0, `frame_err` is set for that character, and the data is still delivered.
- R7: With `two_stop`=1, a high second stop slot returns the receiver to idle. A low second stop slot is taken as the start bit of the next character, and that character is received without a new start confirmation.
- R8: `rx_valid` is a one-cycle pulse, one per character. `rx_data`, `frame_err`, `par_err` and `mp_bit` change only together with that pulse and hold their values between pulses.
- R9: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| clk_sel | input | 2 | Prescaler code (0:/1, 1:/4, 2:/16, 3:/64) |
| rate | input | 8 | Reload value of the oversample rate counter |
| char7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| par_en | input | 1 | Enables the parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | Selects two stop bits |
| mp_mode | input | 1 | Selects multiprocessor format |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| frame_err | output | 1 | First stop bit of the last character was 0 |
| par_err | output | 1 | Parity mismatch on the last character |
| mp_bit | output | 1 | Multiprocessor bit of the last character |

## Verification
The assertions assume that the format inputs (`char7`, `par_en`, `mp_mode`) do not change while a character is being received. If they did, a flag could be computed against a format different from the one the checker sees at the strobe. The bench changes the mode inputs only while the line has been idle high for several bit periods, after the previous character has been delivered. It drives each bit for exactly 16×(rate+1)×divisor cycles, so the receiver's mid-bit samples stay well clear of bit edges despite the two-flop synchroniser.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int OVS       = 16;
    localparam int OVS_W     = $clog2(OVS);
    localparam int HALF_BIT  = OVS / 2;
    localparam int DATA_MAX  = 8;
    localparam int IDX_W     = $clog2(DATA_MAX);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_MPB,
        ST_STOP,
        ST_STOP2
    } rx_state_t;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sfr_prescale.sv
module sfr_prescale #(
    parameter int SEL_W = 2,
    parameter int STEP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             en
);
    localparam int CNT_W = STEP * ((1 << SEL_W) - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < CNT_W; i++)
            if (i < STEP * int'(sel)) mask[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assign en = ((cnt & mask) == mask);
endmodule

// File: rtl/sfr_baud.sv
module sfr_baud #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_en,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [RATE_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (pre_en) begin
            if (cnt == '0) cnt <= rate;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign tick = pre_en && (cnt == '0);
endmodule

// File: rtl/sfr_rx_fsm.sv
module sfr_rx_fsm
    import sfr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                line,
    input  logic                char7,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    input  logic                mp_mode,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                frame_err,
    output logic                par_err,
    output logic                mp_bit
);
    localparam logic [OVS_W-1:0] MID_START = OVS_W'(HALF_BIT - 1);
    localparam logic [OVS_W-1:0] FULL_BIT  = OVS_W'(OVS - 1);

    rx_state_t           state, nxt;
    logic [OVS_W-1:0]    os_cnt;
    logic [IDX_W-1:0]    bit_idx;
    logic [IDX_W-1:0]    last_idx;
    logic [DATA_MAX-1:0] shreg;
    logic                par_bit;
    logic                mpb;
    logic                seen_high;
    logic                bit_due;

    assign last_idx = char7 ? IDX_W'(DATA_MAX - 2) : IDX_W'(DATA_MAX - 1);
    assign bit_due  = tick && (os_cnt == FULL_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (tick && seen_high && !line) nxt = ST_START;
            ST_START: if (tick && os_cnt == MID_START) nxt = line ? ST_IDLE : ST_DATA;
            ST_DATA:  if (bit_due && bit_idx == last_idx)
                          nxt = mp_mode ? ST_MPB : (par_en ? ST_PAR : ST_STOP);
            ST_PAR:   if (bit_due) nxt = ST_STOP;
            ST_MPB:   if (bit_due) nxt = ST_STOP;
            ST_STOP:  if (bit_due) nxt = two_stop ? ST_STOP2 : ST_IDLE;
            ST_STOP2: if (bit_due) nxt = line ? ST_IDLE : ST_DATA;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt    <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            mpb       <= 1'b0;
            seen_high <= 1'b0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
            par_err   <= 1'b0;
            mp_bit    <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (tick) begin
                if (nxt != state || state == ST_IDLE) os_cnt <= '0;
                else                                  os_cnt <= os_cnt + 1'b1;
                if (nxt == ST_IDLE) seen_high <= line;
                if (nxt == ST_DATA && state != ST_DATA) begin
                    bit_idx <= '0;
                    shreg   <= '0;
                end
            end
            if (bit_due) begin
                unique case (state)
                    ST_DATA: begin
                        shreg[bit_idx] <= line;
                        bit_idx        <= bit_idx + 1'b1;
                    end
                    ST_PAR:  par_bit <= line;
                    ST_MPB:  mpb     <= line;
                    ST_STOP: begin
                        rx_valid  <= 1'b1;
                        rx_data   <= shreg;
                        frame_err <= !line;
                        par_err   <= par_en && !mp_mode && ((^shreg ^ par_bit) != par_odd);
                        mp_bit    <= mp_mode && mpb;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
    parameter int RATE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic [RATE_W-1:0] rate,
    input  logic              char7,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              mp_mode,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              par_err,
    output logic              mp_bit
);
    logic line_s;
    logic pre_en;
    logic tick;

    sfr_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
    );

    sfr_prescale #(.SEL_W(SEL_W), .STEP(2)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(clk_sel), .en(pre_en)
    );

    sfr_baud #(.RATE_W(RATE_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .rate(rate), .tick(tick)
    );

    sfr_rx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
        .char7(char7), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .mp_mode(mp_mode),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
        .par_err(par_err), .mp_bit(mp_bit)
    );
endmodule

// File: rtl/sfr_rx_checker.sv
module sfr_rx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       frame_err,
    input logic       par_err,
    input logic       mp_bit,
    input logic       char7,
    input logic       par_en,
    input logic       mp_mode
);
    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(frame_err) && $stable(par_err) && $stable(mp_bit)));

    assert_seven_bit_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && char7) |-> !rx_data[7]);

    assert_mp_no_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mp_mode) |-> !par_err);

    assert_mpbit_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !mp_mode) |-> !mp_bit);

    assert_no_parity_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !par_en) |-> !par_err);
endmodule

bind serial_frame_rx sfr_rx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .frame_err(frame_err), .par_err(par_err), .mp_bit(mp_bit),
    .char7(char7), .par_en(par_en), .mp_mode(mp_mode)
);

// File: tb/serial_frame_rx_test.sv
module serial_frame_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] clk_sel = 2'd0;
    logic [7:0] rate = 8'd3;
    logic       char7 = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic       two_stop = 1'b0, mp_mode = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, frame_err, par_err, mp_bit;

    int checks = 0, fails = 0, nvalid = 0, run = 0, max_run = 0, cycles = 0;
    int bt = 64;
    logic [7:0] hist [0:15];

    always #10 clk = ~clk;

    serial_frame_rx uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .clk_sel(clk_sel), .rate(rate),
        .char7(char7), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .mp_mode(mp_mode), .rx_data(rx_data), .rx_valid(rx_valid),
        .frame_err(frame_err), .par_err(par_err), .mp_bit(mp_bit)
    );

    always @(negedge clk) begin
        cycles++;
        if (rx_valid) begin
            hist[nvalid % 16] = rx_data;
            nvalid++;
            run++;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_speed(logic [1:0] sel, logic [7:0] r);
        int div;
        clk_sel = sel;
        rate = r;
        div = 1 << (2 * sel);
        bt = 16 * (int'(r) + 1) * div;
    endtask

    task automatic send_bit(logic b);
        rxd = b;
        repeat (bt) @(negedge clk);
    endtask

    task automatic idle(int nbits);
        repeat (nbits) send_bit(1'b1);
    endtask

    task automatic send_char(logic [7:0] d, int nd, bit has_x, logic x, logic stp);
        send_bit(1'b0);
        for (int i = 0; i < nd; i++) send_bit(d[i]);
        if (has_x) send_bit(x);
        send_bit(stp);
    endtask

    task automatic t_reset();
        check("R9 rx_data", rx_data, 0);
        check("R9 rx_valid", rx_valid, 0);
        check("R9 flags", {frame_err, par_err, mp_bit}, 0);
    endtask

    task automatic t_basic8();
        int n0 = nvalid;
        send_char(8'hA5, 8, 0, 1'b0, 1'b1);
        idle(2);
        check("R3 count", nvalid - n0, 1);
        check("R3 data 8-bit", rx_data, 8'hA5);
        check("R6 no frame err", frame_err, 0);
        send_char(8'h3C, 8, 0, 1'b0, 1'b1);
        idle(2);
        check("R3 data second", rx_data, 8'h3C);
    endtask

    task automatic t_seven();
        char7 = 1'b1;
        idle(2);
        send_char(8'hD5, 7, 0, 1'b0, 1'b1);
        idle(2);
        check("R3 7-bit data", rx_data, 8'h55);
        char7 = 1'b0;
        idle(2);
    endtask

    task automatic t_parity();
        par_en = 1'b1;
        par_odd = 1'b0;
        idle(2);
        send_char(8'h3C, 8, 1, ^8'h3C, 1'b1);
        idle(2);
        check("R4 even good", par_err, 0);
        check("R4 even data", rx_data, 8'h3C);
        send_char(8'h3D, 8, 1, 1'b0, 1'b1);
        idle(2);
        check("R4 even bad", par_err, 1);
        par_odd = 1'b1;
        idle(2);
        send_char(8'h01, 8, 1, 1'b0, 1'b1);
        idle(2);
        check("R4 odd good", par_err, 0);
        send_char(8'h03, 8, 1, 1'b0, 1'b1);
        idle(2);
        check("R4 odd bad", par_err, 1);
        par_en = 1'b0;
        par_odd = 1'b0;
        idle(2);
    endtask

    task automatic t_mp();
        mp_mode = 1'b1;
        par_en = 1'b1;
        idle(2);
        send_char(8'h81, 8, 1, 1'b1, 1'b1);
        idle(2);
        check("R5 mp bit 1", mp_bit, 1);
        check("R5 parity ignored", par_err, 0);
        check("R5 data", rx_data, 8'h81);
        send_char(8'h80, 8, 1, 1'b0, 1'b1);
        idle(2);
        check("R5 mp bit 0", mp_bit, 0);
        check("R5 parity ignored 2", par_err, 0);
        mp_mode = 1'b0;
        par_en = 1'b0;
        idle(2);
        send_char(8'h18, 8, 0, 1'b0, 1'b1);
        idle(2);
        check("R5 mp bit cleared", mp_bit, 0);
    endtask

    task automatic t_frame();
        int n0 = nvalid;
        send_char(8'h42, 8, 0, 1'b0, 1'b0);
        idle(3);
        check("R6 frame err set", frame_err, 1);
        check("R6 data delivered", rx_data, 8'h42);
        check("R6 single char", nvalid - n0, 1);
        send_char(8'h24, 8, 0, 1'b0, 1'b1);
        idle(2);
        check("R6 frame err clear", frame_err, 0);
    endtask

    task automatic t_noise();
        int n0 = nvalid;
        rxd = 1'b0;
        repeat (bt / 8) @(negedge clk);
        rxd = 1'b1;
        idle(12);
        check("R2 noise rejected", nvalid - n0, 0);
        check("R2 data held", rx_data, 8'h24);
        send_char(8'h5A, 8, 0, 1'b0, 1'b1);
        idle(2);
        check("R2 after noise", rx_data, 8'h5A);
    endtask

    task automatic t_two_stop();
        int n0;
        two_stop = 1'b1;
        idle(2);
        n0 = nvalid;
        send_char(8'h11, 8, 0, 1'b0, 1'b1);
        send_char(8'h22, 8, 0, 1'b0, 1'b1);
        idle(3);
        check("R7 low 2nd stop count", nvalid - n0, 2);
        check("R7 first char", hist[n0 % 16], 8'h11);
        check("R7 second char", rx_data, 8'h22);
        n0 = nvalid;
        send_char(8'h33, 8, 0, 1'b0, 1'b1);
        send_bit(1'b1);
        send_char(8'h44, 8, 0, 1'b0, 1'b1);
        idle(3);
        check("R7 high 2nd stop count", nvalid - n0, 2);
        check("R7 high 2nd stop data", rx_data, 8'h44);
        two_stop = 1'b0;
        idle(2);
    endtask

    task automatic t_speeds();
        for (int s = 1; s < 4; s++) begin
            set_speed(2'(s), 8'd0);
            idle(2);
            send_char(8'h96 ^ 8'(s), 8, 0, 1'b0, 1'b1);
            idle(2);
            check("R1 divider code", rx_data, 8'h96 ^ s);
        end
        set_speed(2'd0, 8'd1);
        idle(2);
        send_char(8'hC3, 8, 0, 1'b0, 1'b1);
        idle(2);
        check("R1 undivided rate 1", rx_data, 8'hC3);
    endtask

    initial begin
        set_speed(2'd0, 8'd3);
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_basic8();
        t_seven();
        t_parity();
        t_mp();
        t_frame();
        t_noise();
        t_two_stop();
        t_speeds();
        check("R8 strobe width", max_run, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule